// File: doc/BRIEF.md
# Synthesizer Serial Register Interface

This block is a two-wire (I2C) slave that receives settings for a frequency synthesizer. A host addresses it with a 7-bit device address. In a write telegram, the data bytes arrive in pairs. The top bit of the first byte of each pair picks the destination: the 16-bit divider word or the 16-bit control word. The second byte of a pair always goes to the same destination as the first. A telegram may carry several pairs, and each pair picks its destination again.

A read telegram returns a status byte that is supplied on an input port. The status byte is shifted out for as long as the host keeps acknowledging. The serial lines arrive already synchronised to the system clock. The block watches them for bus conditions and drives the data line only through an open-drain pull-low output.

Top module: `synth_i2c_regif`

## Requirements
- R1: A fall of SDA while SCL is high starts a telegram, from any state, including in the middle of one. A rise of SDA while SCL is high ends the telegram. After either condition, `sda_pull_o` is low.
- R2: Bits are sampled on SCL rising edges, MSB first. `sda_pull_o` changes only while SCL is low.
- R3: The first byte holds the 7-bit address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). When bits 7..1 equal `dev_addr_i`, the block pulls SDA low through the ninth clock.
- R4: When the address differs, the block gives no acknowledge. It does not acknowledge or store any further byte until the next start condition, and both words stay unchanged.
- R5: In a write telegram, every data byte is acknowledged on its ninth clock.
- R6: When bit 7 of the first byte of a pair is 0, the pair is stored in `div_word_o`. When it is 1, the pair is stored in `ctl_word_o`. The first byte goes to bits 15..8 and the second byte to bits 7..0.
- R7: Data bytes 3, 5 and so on each open a new pair and choose the destination again.
- R8: A word changes only once the second byte of its pair has been received. One pair changes exactly one word.
- R9: A stop or a repeated start after only the first byte of a pair discards that byte. The next data byte then opens a new pair.
- R10: In a read, the block sends `status_i` MSB first. It samples `status_i` when each byte begins and pulls SDA low for 0 bits. It sends another byte after a host acknowledge. After a host not-acknowledge it releases SDA and stays released until the next start.
- R11: After reset, both words are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock, synchronised |
| sda_i | input | 1 | Serial data line level, synchronised |
| sda_pull_o | output | 1 | 1 pulls the SDA line low (open drain) |
| dev_addr_i | input | 7 | Device address to answer |
| status_i | input | 8 | Status byte returned on reads |
| div_word_o | output | 16 | Divider word |
| ctl_word_o | output | 16 | Control word |

## Verification
The hardest situation to reach is a telegram that ends after half a pair. A bare stop test cannot show that the stored first byte was dropped, because nothing on the outputs changes. The stimulus therefore sends one byte and then a stop or a repeated start. It then opens a fresh telegram whose bytes would form a different word if the old byte were wrongly kept. The read path is driven the same way: the status input changes between bytes to show that each byte samples it anew, and a not-acknowledge is followed by extra clocks to confirm SDA stays released.

// File: rtl/synth_i2c_pkg.sv
// Shared types for the synthesizer serial register interface.
package synth_i2c_pkg;

    // Protocol phase of the byte engine.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WRITE,
        PH_WRITE_ACK,
        PH_READ,
        PH_READ_ACK,
        PH_SKIP
    } phase_t;

endpackage

// File: rtl/i2c_line_events.sv
// Line event detector.
// Compares the current line levels with those of the previous clock and
// flags SCL edges and start/stop conditions for one clock.
// Assumes scl_i and sda_i are already synchronous to clk and free of glitches.
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_q;
    logic sda_q;

    // Remember the line levels of the previous clock (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and conditions from the old and new levels.
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        bus_start = scl_i & scl_q & sda_q & ~sda_i;
        bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
// Byte engine.
// Walks each telegram: shifts in the address byte, acknowledges on a match,
// then either receives write bytes (each acknowledged and handed on as a
// one-clock pulse) or shifts out the status byte while the host acknowledges.
// Assumes the host changes SDA only while SCL is low; SDA is driven here only
// at SCL falling edges.
module i2c_byte_engine
    import synth_i2c_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = BYTE_W - 1,
    localparam int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_pull_o,
    output logic              wbyte_vld,
    output logic [BYTE_W-1:0] wbyte
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_half;
    logic              rd_mode;
    logic              host_ack;
    logic [BYTE_W-1:0] shifted;

    // Next shift register contents with the current line level appended.
    always_comb begin
        shifted = {shreg[BYTE_W-2:0], sda_i};
    end

    // Protocol sequencer: one step per detected line event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            ack_half   <= 1'b0;
            rd_mode    <= 1'b0;
            host_ack   <= 1'b0;
            sda_pull_o <= 1'b0;
            wbyte_vld  <= 1'b0;
            wbyte      <= '0;
        end else begin
            wbyte_vld <= 1'b0;
            if (bus_start) begin
                phase      <= PH_ADDR;
                bit_cnt    <= '0;
                ack_half   <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (bus_stop) begin
                phase      <= PH_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= shifted;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt  <= '0;
                                ack_half <= 1'b0;
                                rd_mode  <= sda_i;
                                if (shreg[ADDR_W-1:0] == dev_addr_i) begin
                                    phase <= PH_ADDR_ACK;
                                end else begin
                                    phase <= PH_SKIP;
                                end
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (!ack_half) begin
                                sda_pull_o <= 1'b1;
                                ack_half   <= 1'b1;
                            end else begin
                                ack_half <= 1'b0;
                                bit_cnt  <= '0;
                                if (rd_mode) begin
                                    shreg      <= status_i;
                                    sda_pull_o <= ~status_i[BYTE_W-1];
                                    phase      <= PH_READ;
                                end else begin
                                    sda_pull_o <= 1'b0;
                                    phase      <= PH_WRITE;
                                end
                            end
                        end
                    end
                    PH_WRITE: begin
                        if (scl_rise) begin
                            shreg   <= shifted;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt   <= '0;
                                ack_half  <= 1'b0;
                                wbyte     <= shifted;
                                wbyte_vld <= 1'b1;
                                phase     <= PH_WRITE_ACK;
                            end
                        end
                    end
                    PH_WRITE_ACK: begin
                        if (scl_fall) begin
                            if (!ack_half) begin
                                sda_pull_o <= 1'b1;
                                ack_half   <= 1'b1;
                            end else begin
                                sda_pull_o <= 1'b0;
                                ack_half   <= 1'b0;
                                bit_cnt    <= '0;
                                phase      <= PH_WRITE;
                            end
                        end
                    end
                    PH_READ: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt  <= '0;
                                ack_half <= 1'b0;
                                phase    <= PH_READ_ACK;
                            end
                        end else if (scl_fall) begin
                            shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_pull_o <= ~shreg[BYTE_W-2];
                        end
                    end
                    PH_READ_ACK: begin
                        if (scl_fall && !ack_half) begin
                            sda_pull_o <= 1'b0;
                            ack_half   <= 1'b1;
                        end else if (scl_rise && ack_half) begin
                            host_ack <= ~sda_i;
                        end else if (scl_fall && ack_half) begin
                            ack_half <= 1'b0;
                            if (host_ack) begin
                                shreg      <= status_i;
                                sda_pull_o <= ~status_i[BYTE_W-1];
                                bit_cnt    <= '0;
                                phase      <= PH_READ;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                    end
                    default: begin
                        sda_pull_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pair_sorter.sv
// Pair sorter.
// Groups received write bytes into pairs. The top bit of the first byte of
// each pair selects the destination word (0 = divider, 1 = control), and the
// completed pair is written to that word only. A clear (start or stop)
// discards a half-received pair.
// Assumes wbyte_vld and clear never coincide (a byte ends on an SCL rise,
// and a condition needs SCL to stay high afterwards).
module pair_sorter #(
    parameter int                   BYTE_W  = 8,
    localparam int                  WORD_W  = 2 * BYTE_W,
    parameter logic [2*BYTE_W-1:0]  DIV_RST = '0,
    parameter logic [2*BYTE_W-1:0]  CTL_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wbyte_vld,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [WORD_W-1:0] div_word_o,
    output logic [WORD_W-1:0] ctl_word_o
);

    localparam int N_WORDS = 2;

    logic              have_first;
    logic [BYTE_W-1:0] first_byte;
    logic              commit;
    logic              dest_sel;
    logic [WORD_W-1:0] pair_word;
    logic [WORD_W-1:0] words [N_WORDS];

    // Hold the first byte of a pair until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first <= 1'b0;
            first_byte <= '0;
        end else if (clear) begin
            have_first <= 1'b0;
        end else if (wbyte_vld) begin
            if (!have_first) begin
                have_first <= 1'b1;
                first_byte <= wbyte;
            end else begin
                have_first <= 1'b0;
            end
        end
    end

    // Form the completed pair and its destination.
    always_comb begin
        commit    = wbyte_vld & have_first & ~clear;
        dest_sel  = first_byte[BYTE_W-1];
        pair_word = {first_byte, wbyte};
    end

    // One storage word per destination; index equals the selector value.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] RST_V = (g == 0) ? DIV_RST : CTL_RST;

        // Load this word when a pair addressed to it completes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= RST_V;
            end else if (commit && (dest_sel == 1'(g))) begin
                words[g] <= pair_word;
            end
        end
    end

    assign div_word_o = words[0];
    assign ctl_word_o = words[1];

endmodule

// File: rtl/synth_i2c_regif.sv
// Synthesizer serial register interface, top level.
// A two-wire slave that stores write data pairs into a divider or a control
// word and returns a status byte on reads.
// Assumes synchronised, glitch-free bus inputs; SDA is driven only through
// the open-drain pull-low output.
module synth_i2c_regif #(
    parameter int                  BYTE_W  = 8,
    localparam int                 ADDR_W  = BYTE_W - 1,
    localparam int                 WORD_W  = 2 * BYTE_W,
    parameter logic [2*BYTE_W-1:0] DIV_RST = '0,
    parameter logic [2*BYTE_W-1:0] CTL_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic [WORD_W-1:0] div_word_o,
    output logic [WORD_W-1:0] ctl_word_o
);

    logic              scl_rise;
    logic              scl_fall;
    logic              bus_start;
    logic              bus_stop;
    logic              wbyte_vld;
    logic [BYTE_W-1:0] wbyte;
    logic              pair_clear;

    i2c_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_byte_engine #(.BYTE_W(BYTE_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .sda_i      (sda_i),
        .dev_addr_i (dev_addr_i),
        .status_i   (status_i),
        .sda_pull_o (sda_pull_o),
        .wbyte_vld  (wbyte_vld),
        .wbyte      (wbyte)
    );

    // Any bus condition ends the current pair.
    assign pair_clear = bus_start | bus_stop;

    pair_sorter #(
        .BYTE_W  (BYTE_W),
        .DIV_RST (DIV_RST),
        .CTL_RST (CTL_RST)
    ) u_sorter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pair_clear),
        .wbyte_vld  (wbyte_vld),
        .wbyte      (wbyte),
        .div_word_o (div_word_o),
        .ctl_word_o (ctl_word_o)
    );

endmodule

// File: rtl/synth_i2c_regif_chk.sv
// Property checker for the serial register interface, bound to the top.
// Observes ports only.
module synth_i2c_regif_chk #(
    parameter int                  WORD_W  = 16,
    parameter logic [WORD_W-1:0]   DIV_RST = '0,
    parameter logic [WORD_W-1:0]   CTL_RST = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_pull_o,
    input logic [WORD_W-1:0] div_word_o,
    input logic [WORD_W-1:0] ctl_word_o
);

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (div_word_o == DIV_RST && ctl_word_o == CTL_RST && !sda_pull_o));

    assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull_o);

    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !sda_pull_o);

    assert_div_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word_o) |-> !div_word_o[WORD_W-1]);

    assert_ctl_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_word_o) |-> ctl_word_o[WORD_W-1]);

    assert_single_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(div_word_o) && !$stable(ctl_word_o)));

endmodule

bind synth_i2c_regif synth_i2c_regif_chk #(
    .WORD_W  (WORD_W),
    .DIV_RST (DIV_RST),
    .CTL_RST (CTL_RST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_pull_o (sda_pull_o),
    .div_word_o (div_word_o),
    .ctl_word_o (ctl_word_o)
);

// File: tb/sim_synth_i2c_regif.sv
// Bench for synth_i2c_regif: a behavioural host plus a pair model whose
// expected words are compared with the outputs on every clock.
module sim_synth_i2c_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_h = 1'b1;
    logic [6:0]  dev_addr = 7'h61;
    logic [7:0]  status = 8'h00;
    logic        sda_pull;
    logic        sda;
    logic [15:0] div_word;
    logic [15:0] ctl_word;

    integer checks = 0;
    integer fails = 0;
    logic   cmp_en = 1'b0;
    logic   done = 1'b0;

    logic [15:0] exp_div = 16'h0000;
    logic [15:0] exp_ctl = 16'h0000;
    logic        m_have = 1'b0;
    logic [7:0]  m_first = 8'h00;

    assign sda = sda_h & ~sda_pull;

    always #2 clk = ~clk;

    synth_i2c_regif u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda),
        .sda_pull_o (sda_pull),
        .dev_addr_i (dev_addr),
        .status_i   (status),
        .div_word_o (div_word),
        .ctl_word_o (ctl_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every-clock comparison of both words with the pair model (R6, R8).
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R8 divider word vs model", {16'h0, div_word}, {16'h0, exp_div});
            chk("R8 control word vs model", {16'h0, ctl_word}, {16'h0, exp_ctl});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pair model: first byte selects, second byte completes (R6, R7).
    task automatic model_data(input logic [7:0] b);
        if (!m_have) begin
            m_have  = 1'b1;
            m_first = b;
        end else begin
            m_have = 1'b0;
            if (m_first[7]) exp_ctl = {m_first, b};
            else            exp_div = {m_first, b};
        end
    endtask

    task automatic do_start();
        sda_h = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        sda_h = 1'b0; tick(2);
        scl = 1'b0;   tick(2);
        m_have = 1'b0;
    endtask

    task automatic do_stop();
        sda_h = 1'b0; tick(2);
        scl = 1'b1;   tick(2);
        sda_h = 1'b1; tick(2);
        m_have = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit is_data, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(2);
            if (i == 0 && is_data) cmp_en = 1'b0;
            scl = 1'b1; tick(4);
            scl = 1'b0; tick(2);
        end
        if (is_data) model_data(b);
        cmp_en = 1'b1;
        sda_h = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        acked = sda_pull;
        tick(2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic recv_byte(input bit host_ack, input logic [7:0] nxt, output logic [7:0] d);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2);
            scl = 1'b1; tick(2);
            d[i] = sda;
            tick(2);
            scl = 1'b0;
        end
        status = nxt;
        tick(1);
        sda_h = host_ack ? 1'b0 : 1'b1;
        tick(1);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(2);
        sda_h = 1'b1;
    endtask

    task automatic write_pair_telegram(input logic [7:0] a, input logic [7:0] b);
        bit ak;
        do_start();
        send_byte({dev_addr, 1'b0}, 1'b0, ak);
        chk("R3 address acknowledge", {31'h0, ak}, 32'h1);
        send_byte(a, 1'b1, ak);
        chk("R5 first data byte acknowledge", {31'h0, ak}, 32'h1);
        send_byte(b, 1'b1, ak);
        chk("R5 second data byte acknowledge", {31'h0, ak}, 32'h1);
        do_stop();
    endtask

    initial begin
        bit         ak;
        logic [7:0] rd;
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk("R11 divider reset value", {16'h0, div_word}, 32'h0);
        chk("R11 control reset value", {16'h0, ctl_word}, 32'h0);
        chk("R11 SDA released after reset", {31'h0, sda_pull}, 32'h0);
        cmp_en = 1'b1;

        // R6: divider pair, then control pair.
        write_pair_telegram(8'h12, 8'h34);
        chk("R6 divider word", {16'h0, div_word}, 32'h1234);
        do_start();
        send_byte({dev_addr, 1'b0}, 1'b0, ak);
        send_byte(8'h85, 1'b1, ak);
        chk("R8 control unchanged after first byte", {16'h0, ctl_word}, 32'h0);
        send_byte(8'h6A, 1'b1, ak);
        do_stop();
        chk("R6 control word", {16'h0, ctl_word}, 32'h856A);

        // R7: three pairs in one telegram, selection renewed per pair.
        do_start();
        send_byte({dev_addr, 1'b0}, 1'b0, ak);
        send_byte(8'h05, 1'b1, ak);
        send_byte(8'h06, 1'b1, ak);
        send_byte(8'h8F, 1'b1, ak);
        send_byte(8'h01, 1'b1, ak);
        send_byte(8'h22, 1'b1, ak);
        send_byte(8'h33, 1'b1, ak);
        chk("R5 sixth byte acknowledge", {31'h0, ak}, 32'h1);
        do_stop();
        chk("R7 third pair to divider", {16'h0, div_word}, 32'h2233);
        chk("R7 second pair to control", {16'h0, ctl_word}, 32'h8F01);

        // R4: foreign address, no acknowledge, data ignored.
        do_start();
        send_byte({7'h62, 1'b0}, 1'b0, ak);
        chk("R4 no acknowledge for foreign address", {31'h0, ak}, 32'h0);
        send_byte(8'h11, 1'b0, ak);
        chk("R4 no acknowledge for ignored data", {31'h0, ak}, 32'h0);
        send_byte(8'h22, 1'b0, ak);
        do_stop();
        chk("R4 divider unchanged", {16'h0, div_word}, 32'h2233);
        chk("R4 control unchanged", {16'h0, ctl_word}, 32'h8F01);

        // R9: half pair cut by a stop.
        do_start();
        send_byte({dev_addr, 1'b0}, 1'b0, ak);
        send_byte(8'h12, 1'b1, ak);
        do_stop();
        write_pair_telegram(8'h34, 8'h56);
        chk("R9 half pair dropped at stop", {16'h0, div_word}, 32'h3456);

        // R9/R1: half pair cut by a repeated start.
        do_start();
        send_byte({dev_addr, 1'b0}, 1'b0, ak);
        send_byte(8'h80, 1'b1, ak);
        do_start();
        send_byte({dev_addr, 1'b0}, 1'b0, ak);
        chk("R1 address acknowledged after repeated start", {31'h0, ak}, 32'h1);
        send_byte(8'h01, 1'b1, ak);
        send_byte(8'h02, 1'b1, ak);
        do_stop();
        chk("R9 half pair dropped at repeated start", {16'h0, div_word}, 32'h0102);
        chk("R9 control untouched by dropped byte", {16'h0, ctl_word}, 32'h8F01);

        // R3: the address input is honoured.
        dev_addr = 7'h20;
        do_start();
        send_byte({7'h61, 1'b0}, 1'b0, ak);
        chk("R3 old address refused", {31'h0, ak}, 32'h0);
        do_stop();
        write_pair_telegram(8'h8A, 8'hBC);
        chk("R3 new address stores control", {16'h0, ctl_word}, 32'h8ABC);

        // R10: read two bytes, status changes between them, NACK releases.
        status = 8'hA5;
        do_start();
        send_byte({dev_addr, 1'b1}, 1'b0, ak);
        chk("R3 read address acknowledge", {31'h0, ak}, 32'h1);
        recv_byte(1'b1, 8'h3C, rd);
        chk("R10 first status byte", {24'h0, rd}, 32'hA5);
        recv_byte(1'b0, 8'h00, rd);
        chk("R10 second status byte", {24'h0, rd}, 32'h3C);
        for (int k = 0; k < 3; k++) begin
            tick(2); scl = 1'b1; tick(2);
            chk("R10 SDA released after NACK", {31'h0, sda_pull}, 32'h0);
            tick(2); scl = 1'b0; tick(2);
        end
        do_stop();
        chk("R1 SDA released after stop", {31'h0, sda_pull}, 32'h0);

        // R2: a write still works after the read.
        write_pair_telegram(8'h7E, 8'h81);
        chk("R2 bits taken MSB first", {16'h0, div_word}, 32'h7E81);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule